// File: doc/BRIEF.md
# SPI Master Chip-Select Manager

This block drives the four active-low chip-select lines of an SPI master and decides which of four per-select configuration slots governs each transfer. For every word the shift engine is about to send, it picks a 4-bit target code. The code comes either from a fixed mode-register field or from the word itself. The block then turns the code into line levels in one of two ways. In priority mode, only the lowest-numbered zero bit pulls its line low. In decode mode, the code appears unchanged on the lines so that an external decoder can select up to 15 targets. From the chosen slot it reports the slot index and the number of bits to shift.

The shift engine tells the block when a transfer starts, when it finishes, and whether more data is queued. By default the lines return high once the last queued word has been shifted. A per-slot keep flag holds the lines low between transfers until a different target is addressed. A last-transfer flag in the word forces release. Whenever the target changes while the lines are low, the lines first go all-high for at least one clock. All outputs are registered and change on the clock edge that samples the start or done strobe.

Top module: `spi_cs_manager`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `csN` is 4'hF, `codeErr` is 0, and `slotIdx` and `bitCount` are 0.
- R2: With `modeVar`=0 the target code is `fixedCode`; bits 19:16 of `txWord` have no effect on `csN` or `slotIdx`.
- R3: With `modeVar`=1 the target code is `txWord[19:16]`, so each word can address a different target.
- R4: With `decodeEn`=0, a transfer drives low only the line at the lowest-numbered zero bit of the code, and `slotIdx` is that bit position; at most one line is ever low.
- R5: With `decodeEn`=1, a transfer drives the code itself onto `csN`, and `slotIdx` is code bits 3:2.
- R6: In the cycle after a start, `bitCount` equals the 5-bit field `slotBitsFlat[5*slotIdx +: 5]` of the selected slot.
- R7: A start whose code is 4'hF changes no line and raises `codeErr` for exactly the one cycle after the start.
- R8: A done with `morePending`=0, while the current slot's bit in `keepFlags` is 0, returns `csN` to 4'hF in the next cycle; with `morePending`=1 the lines stay as they are.
- R9: A done while the current slot's keep flag is 1 leaves the lines low. A later start to the same target keeps them low without a break.
- R10: A word with `txWord[24]`=1 releases the lines after its done, even when the keep flag is set or more data is pending.
- R11: A start to a different target while lines are low gives exactly one cycle of 4'hF, followed by the new select.
- R12: A start in the same cycle as a done that releases the lines gives one cycle of 4'hF, then the new select, even when the target is the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modeVar | input | 1 | 0: code from fixedCode, 1: code from each word |
| fixedCode | input | 4 | Mode-register target code |
| decodeEn | input | 1 | 1: drive code directly for external decoding |
| keepFlags | input | 4 | Per-slot keep-asserted flags |
| slotBitsFlat | input | 20 | Four 5-bit bits-per-transfer fields, slot 0 in bits 4:0 |
| xferStart | input | 1 | Shift engine starts the word on txWord |
| txWord | input | 32 | Transmit word: code in 19:16, last flag in 24 |
| xferDone | input | 1 | Shift engine finished the current word |
| morePending | input | 1 | More words queued at done |
| csN | output | 4 | Active-low chip-select lines |
| slotIdx | output | 2 | Selected configuration slot |
| bitCount | output | 5 | Bits to shift for the selected slot |
| codeErr | output | 1 | One-cycle pulse on an unusable code |

## Verification
The two functions that can meet in one cycle are the release decided by a done and the selection of a new target by a start. The bench provokes this by asserting both strobes on the same clock. It does so once with a last-flagged word to the same target and once with a keep-held slot to a different target. Each cycle, a behavioural model judges the outcome: the model requires the one-cycle all-high gap and then the new select, and an assertion rejects any direct switch from one low pattern to another.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  // Strobes sent by the control FSM to the datapath
  typedef struct packed {
    logic loadNew;   // drive the freshly computed target
    logic gapNew;    // force lines high, park the new target
    logic loadPend;  // drive the parked target
    logic release_;  // force lines high, transfer over
    logic flagErr;   // unusable code seen
  } csStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_HELD   = 2'd2,
    ST_GAP    = 2'd3
  } csState_t;
endpackage

// File: rtl/spi_cs_select.sv
module spi_cs_select #(
  parameter int NUM_CS = 4,
  localparam int SLOT_W = $clog2(NUM_CS)
) (
  input  logic [NUM_CS-1:0] code,
  input  logic              decodeEn,
  output logic [NUM_CS-1:0] lines,
  output logic [SLOT_W-1:0] slot
);
  logic [NUM_CS:0]   clearBelow;
  logic [NUM_CS-1:0] pick;
  logic [SLOT_W-1:0] priIdx;

  assign clearBelow[0] = 1'b1;
  for (genvar g = 0; g < NUM_CS; g++) begin : g_pri
    assign pick[g]          = clearBelow[g] & ~code[g];
    assign clearBelow[g+1]  = clearBelow[g] & code[g];
  end

  always_comb begin
    priIdx = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (pick[i]) priIdx = SLOT_W'(i);
    end
  end

  assign lines = decodeEn ? code : ~pick;
  assign slot  = decodeEn ? code[NUM_CS-1 -: SLOT_W] : priIdx;
endmodule

// File: rtl/spi_cs_datapath.sv
module spi_cs_datapath
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int WORD_W   = 32,
  parameter int CODE_LSB = 16,
  parameter int LAST_BIT = 24,
  parameter int BITS_W   = 5,
  localparam int SLOT_W  = $clog2(NUM_CS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     modeVar,
  input  logic [NUM_CS-1:0]        fixedCode,
  input  logic                     decodeEn,
  input  logic [NUM_CS-1:0]        keepFlags,
  input  logic [NUM_CS*BITS_W-1:0] slotBitsFlat,
  input  logic [WORD_W-1:0]        txWord,
  input  csStrobe_t                strobe,
  output logic                     codeValid,
  output logic                     sameTarget,
  output logic                     keepActive,
  output logic                     lastCur,
  output logic [NUM_CS-1:0]        csN,
  output logic [SLOT_W-1:0]        slotIdx,
  output logic [BITS_W-1:0]        bitCount,
  output logic                     codeErr
);
  logic [NUM_CS-1:0] code;
  logic [NUM_CS-1:0] target;
  logic [SLOT_W-1:0] slotSel;
  logic [NUM_CS-1:0] pendReg;
  logic              latchNew;

  assign code = modeVar ? txWord[CODE_LSB +: NUM_CS] : fixedCode;

  spi_cs_select #(.NUM_CS(NUM_CS)) u_select (
    .code    (code),
    .decodeEn(decodeEn),
    .lines   (target),
    .slot    (slotSel)
  );

  assign codeValid  = ~&code;
  assign sameTarget = (target == csN);
  assign keepActive = keepFlags[slotIdx];
  assign latchNew   = strobe.loadNew | strobe.gapNew;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csN     <= '1;
      pendReg <= '1;
    end else if (strobe.loadNew) begin
      csN <= target;
    end else if (strobe.gapNew) begin
      csN     <= '1;
      pendReg <= target;
    end else if (strobe.loadPend) begin
      csN <= pendReg;
    end else if (strobe.release_) begin
      csN <= '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotIdx  <= '0;
      bitCount <= '0;
      lastCur  <= 1'b0;
    end else if (latchNew) begin
      slotIdx  <= slotSel;
      bitCount <= slotBitsFlat[slotSel*BITS_W +: BITS_W];
      lastCur  <= txWord[LAST_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) codeErr <= 1'b0;
    else        codeErr <= strobe.flagErr;
  end
endmodule

// File: rtl/spi_cs_control.sv
module spi_cs_control
  import spi_cs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      xferStart,
  input  logic      xferDone,
  input  logic      morePending,
  input  logic      codeValid,
  input  logic      sameTarget,
  input  logic      keepActive,
  input  logic      lastCur,
  output csStrobe_t strobe
);
  csState_t state, stateNxt;
  logic     relNow, holdNow;

  assign relNow  = xferDone && (state == ST_ACTIVE) &&
                   (lastCur || (!morePending && !keepActive));
  assign holdNow = xferDone && (state == ST_ACTIVE) && !relNow && !morePending;

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    if (xferStart && codeValid) begin
      if (state == ST_IDLE || state == ST_GAP) begin
        strobe.loadNew = 1'b1;
        stateNxt       = ST_ACTIVE;
      end else if (relNow || !sameTarget) begin
        strobe.gapNew = 1'b1;
        stateNxt      = ST_GAP;
      end else begin
        strobe.loadNew = 1'b1;
        stateNxt       = ST_ACTIVE;
      end
    end else begin
      strobe.flagErr = xferStart;
      if (state == ST_GAP) begin
        strobe.loadPend = 1'b1;
        stateNxt        = ST_ACTIVE;
      end else if (relNow) begin
        strobe.release_ = 1'b1;
        stateNxt        = ST_IDLE;
      end else if (holdNow) begin
        stateNxt = ST_HELD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNxt;
  end
endmodule

// File: rtl/spi_cs_manager.sv
module spi_cs_manager
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int WORD_W   = 32,
  parameter int CODE_LSB = 16,
  parameter int LAST_BIT = 24,
  parameter int BITS_W   = 5,
  localparam int SLOT_W  = $clog2(NUM_CS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     modeVar,
  input  logic [NUM_CS-1:0]        fixedCode,
  input  logic                     decodeEn,
  input  logic [NUM_CS-1:0]        keepFlags,
  input  logic [NUM_CS*BITS_W-1:0] slotBitsFlat,
  input  logic                     xferStart,
  input  logic [WORD_W-1:0]        txWord,
  input  logic                     xferDone,
  input  logic                     morePending,
  output logic [NUM_CS-1:0]        csN,
  output logic [SLOT_W-1:0]        slotIdx,
  output logic [BITS_W-1:0]        bitCount,
  output logic                     codeErr
);
  csStrobe_t strobe;
  logic codeValid, sameTarget, keepActive, lastCur;

  spi_cs_control u_control (
    .clk        (clk),
    .rst_n      (rst_n),
    .xferStart  (xferStart),
    .xferDone   (xferDone),
    .morePending(morePending),
    .codeValid  (codeValid),
    .sameTarget (sameTarget),
    .keepActive (keepActive),
    .lastCur    (lastCur),
    .strobe     (strobe)
  );

  spi_cs_datapath #(
    .NUM_CS  (NUM_CS),
    .WORD_W  (WORD_W),
    .CODE_LSB(CODE_LSB),
    .LAST_BIT(LAST_BIT),
    .BITS_W  (BITS_W)
  ) u_datapath (
    .clk         (clk),
    .rst_n       (rst_n),
    .modeVar     (modeVar),
    .fixedCode   (fixedCode),
    .decodeEn    (decodeEn),
    .keepFlags   (keepFlags),
    .slotBitsFlat(slotBitsFlat),
    .txWord      (txWord),
    .strobe      (strobe),
    .codeValid   (codeValid),
    .sameTarget  (sameTarget),
    .keepActive  (keepActive),
    .lastCur     (lastCur),
    .csN         (csN),
    .slotIdx     (slotIdx),
    .bitCount    (bitCount),
    .codeErr     (codeErr)
  );
endmodule

// File: rtl/spi_cs_manager_checker.sv
module spi_cs_manager_checker #(
  parameter int NUM_CS = 4,
  parameter int BITS_W = 5,
  localparam int SLOT_W = $clog2(NUM_CS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              modeVar,
  input logic [NUM_CS-1:0] fixedCode,
  input logic              decodeEn,
  input logic [NUM_CS-1:0] keepFlags,
  input logic              xferStart,
  input logic              xferDone,
  input logic              morePending,
  input logic [NUM_CS-1:0] csN,
  input logic [SLOT_W-1:0] slotIdx,
  input logic [BITS_W-1:0] bitCount,
  input logic              codeErr
);
  // R1: first cycle out of reset is idle
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (&csN && !codeErr && slotIdx == '0 && bitCount == '0));

  // R4: never more than one line low without decoding
  a_r4_single_low: assert property (@(posedge clk) disable iff (!rst_n)
    !decodeEn |-> $onehot0(~csN));

  // R7: fixed unusable code gives an error and no select
  a_r7_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    (xferStart && !modeVar && (&fixedCode) && (&csN) && !xferDone) |=> (codeErr && &csN));

  // R8: done with nothing queued and no keep releases the lines
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (xferDone && !morePending && !keepFlags[slotIdx] && !xferStart) |=> &csN);

  // R11: lines never jump from one low pattern straight to another
  a_r11_gap_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&csN) && !(&$past(csN))) |-> (csN == $past(csN)));
endmodule

bind spi_cs_manager spi_cs_manager_checker #(.NUM_CS(NUM_CS), .BITS_W(BITS_W)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .modeVar    (modeVar),
  .fixedCode  (fixedCode),
  .decodeEn   (decodeEn),
  .keepFlags  (keepFlags),
  .xferStart  (xferStart),
  .xferDone   (xferDone),
  .morePending(morePending),
  .csN        (csN),
  .slotIdx    (slotIdx),
  .bitCount   (bitCount),
  .codeErr    (codeErr)
);

// File: tb/spi_cs_manager_bench.sv
`timescale 1ns/1ps
module spi_cs_manager_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        modeVar = 1'b0;
  logic [3:0]  fixedCode = 4'hF;
  logic        decodeEn = 1'b0;
  logic [3:0]  keepFlags = 4'h0;
  logic [19:0] slotBitsFlat;
  logic        xferStart = 1'b0;
  logic [31:0] txWord = '0;
  logic        xferDone = 1'b0;
  logic        morePending = 1'b0;
  logic [3:0]  csN;
  logic [1:0]  slotIdx;
  logic [4:0]  bitCount;
  logic        codeErr;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit finished = 0;

  always #2 clk = ~clk;

  // slot 0:8, 1:11, 2:13, 3:16
  assign slotBitsFlat = {5'd16, 5'd13, 5'd11, 5'd8};

  spi_cs_manager u_spi_cs_manager (
    .clk(clk), .rst_n(rst_n), .modeVar(modeVar), .fixedCode(fixedCode),
    .decodeEn(decodeEn), .keepFlags(keepFlags), .slotBitsFlat(slotBitsFlat),
    .xferStart(xferStart), .txWord(txWord), .xferDone(xferDone),
    .morePending(morePending), .csN(csN), .slotIdx(slotIdx),
    .bitCount(bitCount), .codeErr(codeErr)
  );

  // Behavioural reference: 0 idle, 1 busy, 2 kept, 3 gap
  int         mMode;
  logic [3:0] mLines, mPark;
  int         mSlot;
  int         mBits;
  bit         mLast, mErr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mMode = 0; mLines = 4'hF; mPark = 4'hF;
      mSlot = 0; mBits = 0; mLast = 0; mErr = 0;
    end else begin
      logic [3:0] c, want;
      int s;
      bit drop;
      c = modeVar ? txWord[19:16] : fixedCode;
      s = 0;
      want = 4'hF;
      if (decodeEn) begin
        want = c;
        s = c / 4;
      end else begin
        for (int i = 3; i >= 0; i--)
          if (c[i] == 1'b0) begin s = i; want = 4'hF ^ (4'h1 << i); end
      end
      drop = xferDone && mMode == 1 &&
             (mLast || (!morePending && !keepFlags[mSlot]));
      mErr = 0;
      if (xferStart && c != 4'hF) begin
        if (mMode == 0 || mMode == 3 || (!drop && want == mLines)) begin
          mLines = want; mMode = 1;
        end else begin
          mLines = 4'hF; mPark = want; mMode = 3;
        end
        mSlot = s;
        mBits = slotBitsFlat[s*5 +: 5];
        mLast = txWord[24];
      end else begin
        if (xferStart) mErr = 1;
        if (mMode == 3) begin
          mLines = mPark; mMode = 1;
        end else if (drop) begin
          mLines = 4'hF; mMode = 0;
        end else if (mMode == 1 && xferDone && !morePending) begin
          mMode = 2;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (csN !== mLines || slotIdx !== 2'(mSlot) || bitCount !== 5'(mBits) ||
          codeErr !== mErr) begin
        errors++;
        $display("FAIL %s: csN=%h slot=%0d bits=%0d err=%0d expected csN=%h slot=%0d bits=%0d err=%0d",
                 curReq, csN, slotIdx, bitCount, codeErr, mLines, mSlot, mBits, mErr);
      end
    end
  end

  function automatic logic [31:0] mk(input logic [3:0] c, input bit last);
    return {7'h0, last, 4'h0, c, 16'hA5C3};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input logic [31:0] w);
    @(negedge clk); xferStart = 1; txWord = w;
    @(negedge clk); xferStart = 0;
  endtask

  task automatic done(input bit more);
    @(negedge clk); xferDone = 1; morePending = more;
    @(negedge clk); xferDone = 0; morePending = 0;
  endtask

  task automatic both(input logic [31:0] w, input bit more);
    @(negedge clk); xferStart = 1; txWord = w; xferDone = 1; morePending = more;
    @(negedge clk); xferStart = 0; xferDone = 0; morePending = 0;
  endtask

  task automatic expectLines(input string req, input logic [3:0] exp);
    checks++;
    if (csN !== exp) begin
      errors++;
      $display("FAIL %s: csN=%h expected %h", req, csN, exp);
    end
  endtask

  initial begin
    // R1 reset state
    idle(2);
    checks++;
    if (csN !== 4'hF || codeErr !== 0 || slotIdx !== 0 || bitCount !== 0) begin
      errors++;
      $display("FAIL R1: csN=%h err=%0d slot=%0d bits=%0d expected F 0 0 0",
               csN, codeErr, slotIdx, bitCount);
    end
    rst_n = 1;
    idle(2);

    // R2 fixed code, word code ignored
    curReq = "R2"; fixedCode = 4'b1101;
    start(mk(4'b1110, 0));
    expectLines("R2", 4'b1101);
    idle(3); done(0); idle(2);

    // R3 per-word code
    curReq = "R3"; modeVar = 1;
    start(mk(4'b1011, 0));
    expectLines("R3", 4'b1011);
    idle(2); done(0); idle(2);

    // R4 several zeros, lowest wins; R6 bit count from slot
    curReq = "R4";
    start(mk(4'b0100, 0));
    expectLines("R4", 4'b1110);
    idle(2); done(0); idle(1);
    curReq = "R6";
    start(mk(4'b0111, 0));
    idle(2); done(0); idle(2);

    // R5 decoded output and slot from upper bits
    curReq = "R5"; decodeEn = 1;
    start(mk(4'h9, 0));
    expectLines("R5", 4'h9);
    idle(2); done(0);
    start(mk(4'hE, 0));
    idle(2); done(0); idle(2);

    // R7 unusable code in both decode settings
    curReq = "R7";
    start(mk(4'hF, 0)); idle(2);
    decodeEn = 0;
    start(mk(4'hF, 0)); idle(2);

    // R8 more pending holds, then release
    curReq = "R8";
    start(mk(4'b1110, 0)); idle(1);
    done(1); idle(2);
    expectLines("R8", 4'b1110);
    start(mk(4'b1110, 0)); idle(1);
    done(0); idle(2);
    expectLines("R8", 4'hF);

    // R9 keep-asserted hold, same target continues, other target gaps (R11)
    curReq = "R9"; keepFlags = 4'b0010;
    start(mk(4'b1101, 0)); idle(1);
    done(0); idle(4);
    expectLines("R9", 4'b1101);
    start(mk(4'b1101, 0)); idle(1);
    done(0); idle(2);
    curReq = "R11";
    start(mk(4'b1011, 0));
    expectLines("R11", 4'hF);
    idle(2); done(0); idle(2);

    // R10 last flag overrides keep and pending data
    curReq = "R10";
    start(mk(4'b1101, 1)); idle(1);
    done(1); idle(1);
    expectLines("R10", 4'hF);
    idle(2);

    // R12 start coinciding with releasing done, same target
    curReq = "R12"; keepFlags = 4'h0;
    start(mk(4'b0111, 1)); idle(1);
    both(mk(4'b0111, 0), 0);
    expectLines("R12", 4'hF);
    idle(1);
    expectLines("R12", 4'b0111);
    done(0); idle(2);
    // coincidence with held slot and different target, decoded
    decodeEn = 1; keepFlags = 4'b0100;
    start(mk(4'h8, 0)); idle(1);
    both(mk(4'h3, 0), 1); idle(2);
    done(0); idle(3);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule